// File: doc/BRIEF.md
# Integer Execute Unit with Iterative Divider

This block is the arithmetic stage of a 32-bit integer pipeline. It receives one already decoded operation together with two register operands, a 16-bit immediate, a 5-bit shift amount and a destination register index. It returns a single result word and a write enable. Adds, logic operations, comparisons, shifts, rotates and multiplies finish in one cycle. Signed and unsigned division use a restoring divider that produces one quotient bit per cycle.

Operations enter through a valid/ready handshake and results leave through a second one. While a result waits at the output, the unit accepts a new operation only in the cycle in which that result is consumed. While a division is running, the unit accepts nothing and raises `busy`.

Division never raises an exception. A zero divisor, or the single signed quotient that cannot be represented, returns the dividend unchanged. The operation codes are the values of the `exu_op_e` enumeration in `exu_pkg`. A code outside that enumeration yields a result of zero.

Top module: `int_exec_unit`

## Requirements
- R1: The register forms compute rA+rB, rA-rB, AND, OR, XOR and NOR of the two operands, modulo 2^32.
- R2: Add-immediate and multiply-immediate sign-extend the 16-bit immediate. AND/OR/XOR-immediate zero-extend it. The three high-half forms use the immediate placed in bits 31:16 with zeros in bits 15:0.
- R3: The six compares (signed GE and LT, NE, EQ, unsigned GE and LT) return 1 when the condition holds and 0 when it does not. In the immediate compare forms, the signed, NE and EQ compares sign-extend the immediate and the unsigned compares zero-extend it.
- R4: Register shifts (left, logical right, arithmetic right) and register rotates (left and right) use only bits 4:0 of rB as the amount.
- R5: Immediate shifts and the immediate left rotate take their amount from the 5-bit `in_shamt` input. rB is not used by these operations.
- R6: The plain multiply and the immediate multiply return the low 32 bits of the product.
- R7: The three high multiplies return bits 63:32 of the 64-bit product, with the operands taken as signed×signed, unsigned×unsigned and signed rA × unsigned rB.
- R8: Signed division truncates toward zero and unsigned division floors. `busy` is high from the accepting edge until the result appears, and `in_ready` is low during that time. The result appears after the 33rd rising edge, counting the accepting edge as the first.
- R9: In unsigned division a zero divisor returns the dividend. In signed division a zero divisor, or a dividend of 0x80000000 with a divisor of 0xFFFFFFFF, also returns the dividend.
- R10: Every non-divide operation presents its result after the accepting edge itself. While `out_ready` stays high, such operations are accepted on consecutive cycles.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_dest` hold their values and no new operation is accepted.
- R12: A result whose destination index is 0 is delivered with `out_wen` low. Any other destination gives `out_wen` high.
- R13: After reset `out_valid` and `busy` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit takes the offered operation this cycle |
| in_op | input | 6 | Operation code (`exu_op_e`) |
| in_a | input | 32 | Operand rA |
| in_b | input | 32 | Operand rB |
| in_imm | input | 16 | Immediate field |
| in_shamt | input | 5 | Immediate shift amount |
| in_dest | input | 5 | Destination register index |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 32 | Result word |
| out_dest | output | 5 | Destination index of the result |
| out_wen | output | 1 | The result is to be written (destination is not 0) |
| busy | output | 1 | A division is in progress |

## Verification
A wrong divider step count or a corrupted partial remainder shows up at the ports only when the quotient arrives. A step count error appears as a result that comes one or more edges early or late relative to the 33-edge latency. A corrupted remainder appears as a wrong quotient, so every division result is compared and its arrival edge is counted. An error in the output slot is visible one cycle after it occurs. A lost hold under backpressure changes `out_data` on the next cycle, and a dropped or duplicated valid breaks the one-to-one order of results in the scoreboard. Errors in the operand extension or the selection of the shift amount stay hidden on easy inputs, so the directed vectors use immediates with bit 15 set and register shift amounts above 31.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [5:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
        OP_ADDI, OP_MULI, OP_ANDI, OP_ORI, OP_XORI,
        OP_ANDHI, OP_ORHI, OP_XORHI,
        OP_CGE, OP_CLT, OP_CNE, OP_CEQ, OP_CGEU, OP_CLTU,
        OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI, OP_CGEUI, OP_CLTUI,
        OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR,
        OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI,
        OP_MUL, OP_MULHSS, OP_MULHUU, OP_MULHSU,
        OP_DIV, OP_DIVU
    } exu_op_e;

    localparam int EXU_OP_COUNT = 41;

endpackage

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 16,
    parameter int SHW  = $clog2(W)
) (
    input  exu_op_e         op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [IMMW-1:0] imm,
    input  logic [SHW-1:0]  shamt,
    output logic [W-1:0]    res
);

    logic [W-1:0]   imm_s, imm_z, imm_h, cmp_b, mul_b;
    logic [SHW-1:0] amt;
    logic           lt_s, lt_u, eq, flag, a_sx, b_sx;
    logic [2*W-1:0] ma, mb, prod;

    assign imm_s = {{(W-IMMW){imm[IMMW-1]}}, imm};
    assign imm_z = {{(W-IMMW){1'b0}}, imm};
    assign imm_h = {imm, {(W-IMMW){1'b0}}};

    // operand selection for compare, shift and multiply
    always_comb begin
        case (op)
            OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI: cmp_b = imm_s;
            OP_CGEUI, OP_CLTUI:                 cmp_b = imm_z;
            default:                            cmp_b = b;
        endcase
        amt   = (op inside {OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI}) ? shamt : b[SHW-1:0];
        mul_b = (op == OP_MULI) ? imm_s : b;
        a_sx  = (op == OP_MULHSS) || (op == OP_MULHSU);
        b_sx  = (op == OP_MULHSS);
    end

    assign lt_s = $signed(a) < $signed(cmp_b);
    assign lt_u = a < cmp_b;
    assign eq   = (a == cmp_b);

    // one shared 2W-bit product serves all multiply variants
    assign ma   = {{W{a_sx & a[W-1]}}, a};
    assign mb   = {{W{b_sx & mul_b[W-1]}}, mul_b};
    assign prod = ma * mb;

    always_comb begin
        case (op)
            OP_CGE, OP_CGEI:   flag = !lt_s;
            OP_CLT, OP_CLTI:   flag = lt_s;
            OP_CNE, OP_CNEI:   flag = !eq;
            OP_CEQ, OP_CEQI:   flag = eq;
            OP_CGEU, OP_CGEUI: flag = !lt_u;
            default:           flag = lt_u;
        endcase
    end

    always_comb begin
        case (op)
            OP_ADD:   res = a + b;
            OP_SUB:   res = a - b;
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_XOR:   res = a ^ b;
            OP_NOR:   res = ~(a | b);
            OP_ADDI:  res = a + imm_s;
            OP_ANDI:  res = a & imm_z;
            OP_ORI:   res = a | imm_z;
            OP_XORI:  res = a ^ imm_z;
            OP_ANDHI: res = a & imm_h;
            OP_ORHI:  res = a | imm_h;
            OP_XORHI: res = a ^ imm_h;
            OP_CGE, OP_CLT, OP_CNE, OP_CEQ, OP_CGEU, OP_CLTU,
            OP_CGEI, OP_CLTI, OP_CNEI, OP_CEQI, OP_CGEUI, OP_CLTUI:
                      res = {{(W-1){1'b0}}, flag};
            OP_SLL, OP_SLLI: res = a << amt;
            OP_SRL, OP_SRLI: res = a >> amt;
            OP_SRA, OP_SRAI: res = $signed(a) >>> amt;
            OP_ROL, OP_ROLI: res = (a << amt) | (a >> (W - int'(amt)));
            OP_ROR:          res = (a >> amt) | (a << (W - int'(amt)));
            OP_MUL, OP_MULI: res = prod[W-1:0];
            OP_MULHSS, OP_MULHUU, OP_MULHSU: res = prod[2*W-1:W];
            default:         res = '0;
        endcase
    end

endmodule

// File: rtl/exu_divider.sv
module exu_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sgn,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int CW = $clog2(W);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          neg;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dsr;
    } div_state_t;

    div_state_t n_d, n_q;
    logic [W:0]   shifted, trial;
    logic [W-1:0] quo_step, b_eff, a_mag, b_mag;
    logic         subst;

    always_comb begin
        n_d      = n_q;
        shifted  = {n_q.rem, n_q.quo[W-1]};
        trial    = shifted - {1'b0, n_q.dsr};
        quo_step = {n_q.quo[W-2:0], ~trial[W]};
        done     = n_q.busy && (n_q.cnt == CW'(W-1));

        // a divisor of one makes the quotient equal the dividend
        subst = (divisor == '0) || (sgn && dividend == MOST_NEG && divisor == '1);
        b_eff = subst ? {{(W-1){1'b0}}, 1'b1} : divisor;
        a_mag = (sgn && dividend[W-1]) ? -dividend : dividend;
        b_mag = (sgn && b_eff[W-1]) ? -b_eff : b_eff;

        if (start) begin
            n_d.busy = 1'b1;
            n_d.cnt  = '0;
            n_d.neg  = sgn && (dividend[W-1] ^ b_eff[W-1]);
            n_d.rem  = '0;
            n_d.quo  = a_mag;
            n_d.dsr  = b_mag;
        end else if (n_q.busy) begin
            n_d.quo = quo_step;
            n_d.rem = trial[W] ? shifted[W-1:0] : trial[W-1:0];
            n_d.cnt = n_q.cnt + CW'(1);
            if (done) n_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign busy     = n_q.busy;
    assign quotient = n_q.neg ? -quo_step : quo_step;

    // R8
    div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R8
    div_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R8
    div_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 16,
    parameter int RIDX = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [5:0]           in_op,
    input  logic [W-1:0]         in_a,
    input  logic [W-1:0]         in_b,
    input  logic [IMMW-1:0]      in_imm,
    input  logic [$clog2(W)-1:0] in_shamt,
    input  logic [RIDX-1:0]      in_dest,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [W-1:0]         out_data,
    output logic [RIDX-1:0]      out_dest,
    output logic                 out_wen,
    output logic                 busy
);

    localparam int SHW = $clog2(W);

    typedef struct packed {
        logic            valid;
        logic [W-1:0]    data;
        logic [RIDX-1:0] dest;
    } slot_t;

    slot_t        s_d, s_q;
    exu_op_e      op;
    logic [W-1:0] alu_res, div_quo;
    logic         div_busy, div_done, op_div, take;

    assign op       = exu_op_e'(in_op);
    assign op_div   = (op == OP_DIV) || (op == OP_DIVU);
    assign in_ready = !div_busy && (!s_q.valid || out_ready);
    assign take     = in_valid && in_ready;

    exu_alu #(.W(W), .IMMW(IMMW), .SHW(SHW)) u_alu (
        .op    (op),
        .a     (in_a),
        .b     (in_b),
        .imm   (in_imm),
        .shamt (in_shamt),
        .res   (alu_res)
    );

    exu_divider #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take && op_div),
        .sgn      (op == OP_DIV),
        .dividend (in_a),
        .divisor  (in_b),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.valid && out_ready) s_d.valid = 1'b0;
        if (take) begin
            s_d.dest = in_dest;
            if (!op_div) begin
                s_d.valid = 1'b1;
                s_d.data  = alu_res;
            end
        end
        if (div_done) begin
            s_d.valid = 1'b1;
            s_d.data  = div_quo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_data  = s_q.data;
    assign out_dest  = s_q.dest;
    assign out_wen   = s_q.valid && (s_q.dest != '0);
    assign busy      = div_busy;

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid && !out_ready |=> s_q.valid && $stable(s_q.data) && $stable(s_q.dest));
    // R8
    slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> !s_q.valid);

endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
    import exu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [15:0] in_imm = '0;
    logic [4:0]  in_shamt = '0, in_dest = '0;
    logic        out_valid, out_wen, busy;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [4:0]  out_dest;

    always #4 clk = ~clk; // 125 MHz

    int_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
        .in_shamt(in_shamt), .in_dest(in_dest), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_dest(out_dest),
        .out_wen(out_wen), .busy(busy)
    );

    typedef struct {
        logic [31:0] data;
        logic [4:0]  dest;
        logic        wen;
        int          acc;
        int          lat;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0, fails = 0, cyc = 0;
    bit   stall = 0, prev_div = 0, done_flag = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(exu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR: return "R1";
            OP_ADDI, OP_ANDI, OP_ORI, OP_XORI, OP_ANDHI, OP_ORHI, OP_XORHI, OP_MULI: return "R2";
            OP_SLL, OP_SRL, OP_SRA, OP_ROL, OP_ROR: return "R4";
            OP_SLLI, OP_SRLI, OP_SRAI, OP_ROLI: return "R5";
            OP_MUL: return "R6";
            OP_MULHSS, OP_MULHUU, OP_MULHSU: return "R7";
            OP_DIV, OP_DIVU: return "R8";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [31:0] model(exu_op_e op, logic [31:0] a, logic [31:0] b,
                                          logic [15:0] im, logic [4:0] sh);
        logic [31:0] se = {{16{im[15]}}, im};
        logic [31:0] ze = {16'h0, im};
        logic [31:0] hi = {im, 16'h0};
        int          rs = int'(b[4:0]);
        int          is = int'(sh);
        logic [63:0] p;
        case (op)
            OP_ADD:   return a + b;
            OP_SUB:   return a - b;
            OP_AND:   return a & b;
            OP_OR:    return a | b;
            OP_XOR:   return a ^ b;
            OP_NOR:   return ~(a | b);
            OP_ADDI:  return a + se;
            OP_MULI:  return a * se;
            OP_ANDI:  return a & ze;
            OP_ORI:   return a | ze;
            OP_XORI:  return a ^ ze;
            OP_ANDHI: return a & hi;
            OP_ORHI:  return a | hi;
            OP_XORHI: return a ^ hi;
            OP_CGE:   return {31'b0, $signed(a) >= $signed(b)};
            OP_CLT:   return {31'b0, $signed(a) < $signed(b)};
            OP_CNE:   return {31'b0, a != b};
            OP_CEQ:   return {31'b0, a == b};
            OP_CGEU:  return {31'b0, a >= b};
            OP_CLTU:  return {31'b0, a < b};
            OP_CGEI:  return {31'b0, $signed(a) >= $signed(se)};
            OP_CLTI:  return {31'b0, $signed(a) < $signed(se)};
            OP_CNEI:  return {31'b0, a != se};
            OP_CEQI:  return {31'b0, a == se};
            OP_CGEUI: return {31'b0, a >= ze};
            OP_CLTUI: return {31'b0, a < ze};
            OP_SLL:   return a << rs;
            OP_SRL:   return a >> rs;
            OP_SRA:   return $signed(a) >>> rs;
            OP_ROL:   return (a << rs) | (a >> (32 - rs));
            OP_ROR:   return (a >> rs) | (a << (32 - rs));
            OP_SLLI:  return a << is;
            OP_SRLI:  return a >> is;
            OP_SRAI:  return $signed(a) >>> is;
            OP_ROLI:  return (a << is) | (a >> (32 - is));
            OP_MUL:   return a * b;
            OP_MULHSS: begin p = {{32{a[31]}}, a} * {{32{b[31]}}, b}; return p[63:32]; end
            OP_MULHUU: begin p = {32'h0, a} * {32'h0, b}; return p[63:32]; end
            OP_MULHSU: begin p = {{32{a[31]}}, a} * {32'h0, b}; return p[63:32]; end
            OP_DIV: begin
                if (b == 0 || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) return a;
                return $signed(a) / $signed(b);
            end
            OP_DIVU: begin
                if (b == 0) return a;
                return a / b;
            end
            default:  return 32'h0;
        endcase
    endfunction

    task automatic send(input exu_op_e op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [4:0] sh, input logic [4:0] dst,
                        input string tag);
        exp_t e;
        int   waits = 0;
        bit   d = (op == OP_DIV) || (op == OP_DIVU);
        @(negedge clk);
        in_op = op; in_a = a; in_b = b; in_imm = im; in_shamt = sh; in_dest = dst;
        in_valid = 1'b1;
        forever begin
            #1;
            if (in_ready) break;
            waits++;
            @(negedge clk);
        end
        e.data = model(op, a, b, im, sh);
        e.dest = dst;
        e.wen  = (dst != 0);
        e.acc  = cyc;
        e.lat  = d ? 33 : 1;
        e.tag  = tag;
        q.push_back(e);
        // R10: with no backpressure, a non-divide successor is taken at once
        if (!stall && !prev_div) chk(waits == 0, "R10 back-to-back acceptance", waits, 0);
        prev_div = d;
        @(posedge clk);
        #1 in_valid = 1'b0;
        if (d) begin
            @(negedge clk);
            #1 chk(busy && !in_ready, "R8 busy and no acceptance during division",
                   {30'b0, busy, in_ready}, 32'h2);
        end
    endtask

    // scoreboard monitor
    initial begin
        bit          pend = 0, fresh = 1;
        logic [31:0] pd;
        logic [4:0]  pdest;
        exp_t        e;
        forever begin
            @(negedge clk);
            out_ready = stall ? ($urandom_range(2) == 0) : 1'b1;
            #2;
            if (!rst_n || done_flag) begin
                pend = 0;
                continue;
            end
            // R11: a stalled result must not move
            if (pend) chk(out_valid && out_data == pd && out_dest == pdest,
                          "R11 result held under backpressure", out_data, pd);
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R10 output with no operation pending", out_data, 0);
                end else begin
                    if (fresh) begin
                        chk(cyc - q[0].acc == q[0].lat, {q[0].tag, " latency"},
                            cyc - q[0].acc, q[0].lat);
                        fresh = 0;
                    end
                    if (out_ready) begin
                        e = q.pop_front();
                        chk(out_data == e.data, {e.tag, " data"}, out_data, e.data);
                        chk(out_dest == e.dest && out_wen == e.wen, "R12 dest and write enable",
                            {26'b0, out_wen, out_dest}, {26'b0, e.wen, e.dest});
                        fresh = 1;
                    end
                end
                pend  = !out_ready;
                pd    = out_data;
                pdest = out_dest;
            end else begin
                pend = 0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done_flag) begin
            done_flag = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=%0d expected<=%0d", cyc, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk(!out_valid && !busy && in_ready, "R13 state in reset",
               {29'b0, out_valid, busy, in_ready}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(!out_valid && !busy && in_ready, "R13 state after reset",
               {29'b0, out_valid, busy, in_ready}, 32'h1);

        // directed vectors
        send(OP_ADD,  32'd7, 32'd5, 16'h0, 5'd0, 5'd3, "R1 add");
        send(OP_SUB,  32'd3, 32'd5, 16'h0, 5'd0, 5'd3, "R1 sub wraps");
        send(OP_NOR,  32'h0F0F_0000, 32'h0000_00FF, 16'h0, 5'd0, 5'd4, "R1 nor");
        send(OP_ADDI, 32'd10, 32'h0, 16'hFFFF, 5'd0, 5'd5, "R2 addi negative");
        send(OP_MULI, 32'd3, 32'h0, 16'hFFFE, 5'd0, 5'd5, "R2 muli negative");
        send(OP_ANDHI,32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd0, 5'd6, "R2 andhi");
        send(OP_ORHI, 32'h0000_1234, 32'h0, 16'hABCD, 5'd0, 5'd6, "R2 orhi");
        send(OP_XORI, 32'hFFFF_FFFF, 32'h0, 16'h8000, 5'd0, 5'd6, "R2 xori zero-extends");
        send(OP_CGEI, 32'h0, 32'h0, 16'h8000, 5'd0, 5'd7, "R3 cgei sign-extends");
        send(OP_CGEUI,32'h0, 32'h0, 16'h8000, 5'd0, 5'd7, "R3 cgeui zero-extends");
        send(OP_CLTU, 32'h1, 32'hFFFF_FFFF, 16'h0, 5'd0, 5'd7, "R3 cltu");
        send(OP_CLT,  32'h1, 32'hFFFF_FFFF, 16'h0, 5'd0, 5'd7, "R3 clt");
        send(OP_SLL,  32'h1, 32'h21, 16'h0, 5'd9, 5'd8, "R4 sll masked amount");
        send(OP_ROR,  32'h1234_5678, 32'hFFFF_FFE4, 16'h0, 5'd0, 5'd8, "R4 ror");
        send(OP_ROL,  32'h8000_0001, 32'h20, 16'h0, 5'd3, 5'd8, "R4 rol by zero");
        send(OP_SRAI, 32'h8000_0000, 32'h1F, 16'h0, 5'd4, 5'd9, "R5 srai ignores rB");
        send(OP_ROLI, 32'h8000_0001, 32'h0, 16'h0, 5'd1, 5'd9, "R5 roli");
        send(OP_MUL,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 5'd10, "R6 mul low");
        send(OP_MULHSS,32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 5'd10, "R7 mulhss");
        send(OP_MULHUU,32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 5'd10, "R7 mulhuu");
        send(OP_MULHSU,32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 5'd10, "R7 mulhsu");
        send(OP_DIV,  32'hFFFF_FFF9, 32'd2, 16'h0, 5'd0, 5'd11, "R8 signed div truncates");
        send(OP_DIVU, 32'd100, 32'd7, 16'h0, 5'd0, 5'd11, "R8 unsigned div");
        send(OP_DIV,  32'hFFFF_FFFB, 32'h0, 16'h0, 5'd0, 5'd12, "R9 signed div by zero");
        send(OP_DIV,  32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'd0, 5'd12, "R9 signed overflow");
        send(OP_DIVU, 32'hDEAD_BEEF, 32'h0, 16'h0, 5'd0, 5'd12, "R9 unsigned div by zero");
        send(OP_ADD,  32'd1, 32'd1, 16'h0, 5'd0, 5'd0, "R12 dest zero");

        // random vectors, first without then with backpressure
        for (int ph = 0; ph < 2; ph++) begin
            stall = (ph == 1);
            for (int k = 0; k < EXU_OP_COUNT; k++) begin
                for (int j = 0; j < 6; j++) begin
                    send(exu_op_e'(k), $urandom, $urandom, 16'($urandom),
                         5'($urandom), 5'($urandom), tag_of(exu_op_e'(k)));
                end
            end
        end

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done_flag = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule